// File: doc/BRIEF.md
# Content-Directed Pointer Detector

When a cache miss is filled, this block inspects the returned line and looks for words that seem to hold addresses. Those words are offered as prefetch candidates. The line arrives as one wide vector, together with a one-cycle strobe and the address of the miss. The line is cut into 32-bit words, and every word is judged on its own. The judgement compares the word's upper byte with the miss address, uses a four-bit field below that byte for values near zero or near all-ones, and requires word alignment.

In one cycle the block judges every word of the line. It writes the accepted words into a small candidate queue, keeping the order of the words in the line. The queue hands candidates out one at a time over a valid/ready pair. The queue may not have room for every accepted word of a line. In that case the words that do not fit are discarded and a one-cycle overflow pulse is raised. Sending the candidates to memory, and following pointers found in prefetched lines, are left to the surrounding logic.

Top module: `ptr_detector`

## Requirements
- R1: After reset, `cand_valid_o` and `overflow_o` are low until a line is accepted.
- R2: Word i of the line is `line_data_i[32*i+31 : 32*i]`, with i from 0 to 15. Each word is judged alone, and its decision does not depend on the other words.
- R3: An aligned word whose bits [31:24] equal bits [31:24] of `miss_addr_i` is accepted. This holds even when that byte is zero.
- R4: Take a word whose bits [31:24] are all zero and differ from the miss address's bits [31:24]. It is accepted only if its bits [23:20] are not all zero.
- R5: A word whose bits [31:24] are all one and whose bits [23:20] are all zero is accepted.
- R6: A word whose bits [1:0] are not 00 is never accepted.
- R7: A word whose bits [31:6] equal bits [31:6] of the miss address lies in the missed 64-byte line. Such a word is never accepted.
- R8: The words accepted from a line enter the queue in ascending word index. They leave the queue oldest first. The first of them can be seen on the outputs in the cycle after the clock edge that sampled `line_valid_i`.
- R9: The queue holds 8 candidates. Free space is counted before any pop in the same cycle. Accepted words beyond the free space are dropped, and the lowest word indices are kept. When any word is dropped, `overflow_o` is high for exactly the one cycle after that edge.
- R10: A candidate is removed only on a cycle where `cand_valid_o` and `cand_ready_i` are both high, and at most one is removed per cycle. While `cand_valid_o` is high and `cand_ready_i` is low, `cand_valid_o` and `cand_addr_o` stay unchanged.
- R11: A word that matches none of the rules of R3 to R5 is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| line_valid_i | input | 1 | One-cycle strobe: the line and the miss address are valid |
| line_data_i | input | 512 | Returned cache line, word 0 in the low bits |
| miss_addr_i | input | 32 | Address whose miss brought the line |
| cand_valid_o | output | 1 | A prefetch candidate is offered |
| cand_ready_i | input | 1 | The consumer takes the offered candidate |
| cand_addr_o | output | 32 | Candidate prefetch address |
| overflow_o | output | 1 | One-cycle pulse: candidates of the last line were dropped |

## Verification
The classifier is driven with single lines that place one word at each edge of each rule. These include a misaligned copy of a good address, a zero top byte with a zero and with a non-zero filter field, an all-ones top byte with both filter cases, an address inside the missed line, and an unrelated top byte. Any rule that is too loose or too strict therefore shows up as an extra or a missing candidate. Sparse lines with accepted words at indices 0, 9 and 15 separate a correct word order from a reversed or shifted one. Lines with more than the free space, sent into an empty queue, a partly filled queue and a full queue, separate correct dropping and pulse timing from off-by-one errors in the free-space count. Random lines with a toggling ready show whether the handshake and the hold behaviour survive writes and pops in the same cycle.

// File: rtl/ptrdet_pkg.sv
package ptrdet_pkg;

    // Which rule accepted a word; CLS_NONE means rejected.
    typedef enum logic [1:0] {
        CLS_NONE    = 2'd0,
        CLS_REGION  = 2'd1,
        CLS_LOWPTR  = 2'd2,
        CLS_HIGHPTR = 2'd3
    } ptr_class_e;

endpackage

// File: rtl/pd_word_classifier.sv
module pd_word_classifier
    import ptrdet_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned CMP_LSB    = 24,
    parameter int unsigned FLT_LSB    = 20,
    parameter int unsigned LINE_OFF_W = 6
) (
    input  logic [ADDR_W-1:0] word_i,
    input  logic [ADDR_W-1:0] miss_i,
    output ptr_class_e        cls_o,
    output logic              accept_o
);

    localparam int unsigned CMP_W = ADDR_W - CMP_LSB;
    localparam int unsigned FLT_W = CMP_LSB - FLT_LSB;

    logic [CMP_W-1:0] cmp_word;
    logic [CMP_W-1:0] cmp_miss;
    logic [FLT_W-1:0] flt_word;
    logic             aligned;
    logic             in_miss_line;

    always_comb begin
        cmp_word     = word_i[ADDR_W-1:CMP_LSB];
        cmp_miss     = miss_i[ADDR_W-1:CMP_LSB];
        flt_word     = word_i[CMP_LSB-1:FLT_LSB];
        aligned      = (word_i[1:0] == 2'b00);
        in_miss_line = (word_i[ADDR_W-1:LINE_OFF_W] == miss_i[ADDR_W-1:LINE_OFF_W]);

        cls_o = CLS_NONE;
        if (aligned && !in_miss_line) begin
            if (cmp_word == cmp_miss)
                cls_o = CLS_REGION;
            else if ((cmp_word == '0) && (flt_word != '0))
                cls_o = CLS_LOWPTR;
            else if ((cmp_word == '1) && (flt_word == '0))
                cls_o = CLS_HIGHPTR;
        end
        accept_o = (cls_o != CLS_NONE);
    end

endmodule

// File: rtl/pd_cand_fifo.sv
module pd_cand_fifo #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned N_IN   = 16
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       wr_en_i,
    input  logic [N_IN-1:0]            acc_i,
    input  logic [N_IN-1:0][ADDR_W-1:0] words_i,
    input  logic                       ready_i,
    output logic                       valid_o,
    output logic [ADDR_W-1:0]          data_o,
    output logic                       ovf_o
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] mem;
        logic [PTR_W-1:0]             rd;
        logic [PTR_W-1:0]             wr;
        logic [CNT_W-1:0]             cnt;
        logic                         ovf;
    } fifo_state_t;

    fifo_state_t      state_d, state_q;
    logic             pop;
    logic [PTR_W-1:0] slot;
    int               free_slots;
    int               n_acc;
    int               n_wr;

    initial begin
        assert (DEPTH == (1 << PTR_W))
            else $error("candidate queue depth must be a power of two");
    end

    always_comb begin
        state_d    = state_q;
        pop        = (state_q.cnt != '0) && ready_i;
        free_slots = int'(DEPTH) - int'(state_q.cnt);
        n_acc      = 0;
        n_wr       = 0;
        slot       = state_q.wr;
        if (wr_en_i) begin
            for (int i = 0; i < int'(N_IN); i++) begin
                if (acc_i[i]) begin
                    if (n_acc < free_slots) begin
                        slot                = state_q.wr + PTR_W'(n_acc);
                        state_d.mem[slot]   = words_i[i];
                        n_wr                = n_wr + 1;
                    end
                    n_acc = n_acc + 1;
                end
            end
        end
        if (pop)
            state_d.rd = state_q.rd + PTR_W'(1);
        state_d.wr  = state_q.wr + PTR_W'(n_wr);
        state_d.cnt = state_q.cnt + CNT_W'(n_wr) - CNT_W'(pop);
        state_d.ovf = wr_en_i && (n_acc > free_slots);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign valid_o = (state_q.cnt != '0);
    assign data_o  = state_q.mem[state_q.rd];
    assign ovf_o   = state_q.ovf;

    // R9: occupancy never exceeds the queue depth
    a_r9_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q.cnt <= CNT_W'(DEPTH));

    // R9: a drop leaves the queue full, minus at most one pop
    a_r9_ovf_means_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |-> (state_q.cnt >= CNT_W'(DEPTH - 1)));

    // R9: the pulse only follows a written line
    a_r9_ovf_after_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |-> $past(wr_en_i));

    // R10: a stalled candidate holds
    a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));

endmodule

// File: rtl/ptr_detector.sv
module ptr_detector
    import ptrdet_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LINE_BYTES = 64,
    parameter int unsigned FIFO_DEPTH = 8,
    parameter int unsigned CMP_LSB    = 24,
    parameter int unsigned FLT_LSB    = 20
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      line_valid_i,
    input  logic [LINE_BYTES*8-1:0]   line_data_i,
    input  logic [ADDR_W-1:0]         miss_addr_i,
    output logic                      cand_valid_o,
    input  logic                      cand_ready_i,
    output logic [ADDR_W-1:0]         cand_addr_o,
    output logic                      overflow_o
);

    localparam int unsigned N_WORDS    = (LINE_BYTES * 8) / ADDR_W;
    localparam int unsigned LINE_OFF_W = $clog2(LINE_BYTES);

    logic [N_WORDS-1:0][ADDR_W-1:0] line_words;
    logic [N_WORDS-1:0]             word_acc;
    ptr_class_e                     word_cls [N_WORDS];

    assign line_words = line_data_i;

    for (genvar g = 0; g < int'(N_WORDS); g++) begin : g_word
        pd_word_classifier #(
            .ADDR_W     (ADDR_W),
            .CMP_LSB    (CMP_LSB),
            .FLT_LSB    (FLT_LSB),
            .LINE_OFF_W (LINE_OFF_W)
        ) cls_i (
            .word_i   (line_words[g]),
            .miss_i   (miss_addr_i),
            .cls_o    (word_cls[g]),
            .accept_o (word_acc[g])
        );
    end

    pd_cand_fifo #(
        .ADDR_W (ADDR_W),
        .DEPTH  (FIFO_DEPTH),
        .N_IN   (N_WORDS)
    ) fifo_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_en_i (line_valid_i),
        .acc_i   (word_acc),
        .words_i (line_words),
        .ready_i (cand_ready_i),
        .valid_o (cand_valid_o),
        .data_o  (cand_addr_o),
        .ovf_o   (overflow_o)
    );

    // R6: every offered candidate is word aligned
    a_r6_aligned_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cand_valid_o |-> (cand_addr_o[1:0] == 2'b00));

    // R8: nothing appears without a line having been written
    a_r8_valid_needs_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cand_valid_o) |-> $past(line_valid_i));

endmodule

// File: tb/ptr_detector_tb_top.sv
module ptr_detector_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         line_valid = 1'b0;
    logic [511:0] line_data = '0;
    logic [31:0]  miss_addr = '0;
    logic         cand_valid;
    logic         cand_ready = 1'b0;
    logic [31:0]  cand_addr;
    logic         overflow;

    int n_checks = 0;
    int n_fail   = 0;
    int ready_mode = 1;   // 0 low, 1 high, 2 toggle
    bit mon_on = 0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic [31:0] w [16];

    always #4 clk = ~clk;   // 125 MHz

    ptr_detector dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .line_valid_i (line_valid),
        .line_data_i  (line_data),
        .miss_addr_i  (miss_addr),
        .cand_valid_o (cand_valid),
        .cand_ready_i (cand_ready),
        .cand_addr_o  (cand_addr),
        .overflow_o   (overflow)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit model_ok(input logic [31:0] x, input logic [31:0] m);
        if (x[1:0] != 2'b00) return 0;
        if (x[31:6] == m[31:6]) return 0;
        if (x[31:24] == m[31:24]) return 1;
        if (x[31:24] == 8'h00 && x[23:20] != 4'h0) return 1;
        if (x[31:24] == 8'hFF && x[23:20] == 4'h0) return 1;
        return 0;
    endfunction

    task automatic tick();
        @(negedge clk);
        #1;
        case (ready_mode)
            0: cand_ready = 1'b0;
            1: cand_ready = 1'b1;
            default: cand_ready = ~cand_ready;
        endcase
    endtask

    task automatic clear_words();
        for (int i = 0; i < 16; i++) w[i] = 32'h0;
    endtask

    task automatic send_line(input logic [31:0] m, input string tag);
        logic [31:0] pend [$];
        int free_n;
        int n_acc;
        bit ovf_exp;
        tick();
        free_n = 8 - exp_q.size();
        n_acc = 0;
        for (int i = 0; i < 16; i++) begin
            line_data[32*i +: 32] = w[i];
            if (model_ok(w[i], m)) begin
                if (n_acc < free_n) pend.push_back(w[i]);
                n_acc++;
            end
        end
        ovf_exp = (n_acc > free_n);
        miss_addr = m;
        line_valid = 1'b1;
        tick();
        line_valid = 1'b0;
        foreach (pend[k]) begin
            exp_q.push_back(pend[k]);
            tag_q.push_back(tag);
        end
        check(overflow == ovf_exp, "R9 overflow pulse", 32'(overflow), 32'(ovf_exp));
    endtask

    task automatic drain();
        ready_mode = 1;
        for (int k = 0; k < 40 && exp_q.size() != 0; k++) tick();
        tick();
        tick();
        check(cand_valid == 1'b0, "R11 no extra candidate", 32'(cand_valid), 32'h0);
        check(overflow == 1'b0, "R9 pulse ends", 32'(overflow), 32'h0);
    endtask

    // Monitor: compares the offered candidate against the scoreboard head.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (mon_on) begin
                if (exp_q.size() == 0) begin
                    check(cand_valid == 1'b0, "R11 unexpected candidate", cand_addr, 32'h0);
                end else begin
                    check(cand_valid == 1'b1, {tag_q[0], " valid"}, 32'(cand_valid), 32'h1);
                    check(cand_addr == exp_q[0], {tag_q[0], " address"}, cand_addr, exp_q[0]);
                    if (cand_valid && cand_ready) begin
                        void'(exp_q.pop_front());
                        void'(tag_q.pop_front());
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(cand_valid == 1'b0, "R1 valid after reset", 32'(cand_valid), 32'h0);
        check(overflow == 1'b0, "R1 overflow after reset", 32'(overflow), 32'h0);
        mon_on = 1;

        // R3/R4/R5/R6/R7/R11: one word at each rule edge
        ready_mode = 1;
        clear_words();
        w[0] = 32'h4000_2340;   // R3 same region
        w[1] = 32'h4000_2342;   // R6 misaligned
        w[2] = 32'h0030_0100;   // R4 zero top, filter nonzero
        w[3] = 32'h0000_F000;   // R4 zero top, filter zero
        w[4] = 32'hFF0F_FFF8;   // R5 all-ones top, filter zero
        w[5] = 32'hFF1F_0000;   // R5 all-ones top, filter nonzero
        w[6] = 32'h4000_1020;   // R7 inside missed line
        w[7] = 32'h1234_5678;   // R11 unrelated
        send_line(32'h4000_1004, "R3-R5 rules");
        drain();

        // R3: zero top byte matching a zero miss region
        clear_words();
        w[3] = 32'h0000_0040;
        w[4] = 32'h0000_0003;   // R6 misaligned
        send_line(32'h0012_3400, "R3 zero region");
        drain();

        // R2/R8: sparse words, ascending order
        clear_words();
        w[15] = 32'h4000_9000;
        w[9]  = 32'h0050_0000;
        w[0]  = 32'hFF00_0010;
        send_line(32'h4000_1000, "R8 order");
        drain();

        // R10: stall then release
        ready_mode = 0;
        clear_words();
        w[1] = 32'h4000_A000;
        w[5] = 32'h4000_B000;
        w[6] = 32'h4000_C000;
        send_line(32'h4000_1000, "R10 hold");
        repeat (5) tick();
        drain();

        // R9: overflow into an empty queue, then into a full one
        ready_mode = 0;
        clear_words();
        for (int i = 0; i < 12; i++) w[i] = 32'h4000_8000 + 32'(i * 64);
        send_line(32'h4000_1000, "R9 overflow");
        tick();
        check(overflow == 1'b0, "R9 single-cycle pulse", 32'(overflow), 32'h0);
        clear_words();
        w[2] = 32'h4000_F000;
        send_line(32'h4000_1000, "R9 full drop");
        drain();

        // R9: partly filled queue
        ready_mode = 0;
        clear_words();
        for (int i = 0; i < 5; i++) w[i] = 32'h4100_0000 + 32'(i * 4);
        send_line(32'h4100_4000, "R9 first half");
        clear_words();
        for (int i = 10; i < 15; i++) w[i] = 32'h0020_0000 + 32'(i * 8);
        send_line(32'h4100_4000, "R9 partial");
        drain();

        // Random lines with a toggling ready
        ready_mode = 2;
        for (int n = 0; n < 40; n++) begin
            for (int i = 0; i < 16; i++) begin
                case ($urandom_range(0, 4))
                    0: w[i] = {8'h40, 24'($urandom)};
                    1: w[i] = {8'h00, 24'($urandom)};
                    2: w[i] = {8'hFF, 4'($urandom_range(0, 1)), 20'($urandom)};
                    3: w[i] = 32'h4000_1000 | 32'($urandom_range(0, 63));
                    default: w[i] = $urandom;
                endcase
            end
            send_line(32'h4000_1000 + 32'(n * 4), "R2 random");
            repeat ($urandom_range(0, 6)) tick();
        end
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule